// File: doc/BRIEF.md
# Two-Road Traffic Light Sequencer

This block drives the lamps at a crossing of a north-south road and an east-west road. A four-phase controller moves between "east-west go", "east-west warning", "north-south go" and "north-south warning". A modulo counter, the cycle timer, paces it: its terminal count raises an advance flag once every five steps, so each road gets four steps of green, one step of yellow and five steps of red.

A clock-enable divider slows the whole block down. It raises a one-cycle step enable every `DIV_RATIO` system clocks. The timer and the controller move only on that enable. The six lamp drives are registered and active-low, so a lamp change appears one step after the phase change that causes it.

An optional override pair lets an outside source stand in for the internal advance flag. This is useful for stretching or shortening green time during bring-up. The `HAS_OVERRIDE` parameter removes the pair from the logic when it is not wanted.

Top module: `traffic_seq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to east-west go and clears the divider and timer. The lamps then read north-south red on, east-west green on and all others off. Written {ns_red_n, ns_yel_n, ns_grn_n, ew_red_n, ew_yel_n, ew_grn_n}, that is 6'b011110.
- R2: Nothing changes except on a step enable. The enable occurs on every `DIV_RATIO`-th clock after reset is released. On all other clocks the lamps hold their value.
- R3: The cycle timer counts steps modulo `TIMER_MOD` (default 5), starting from 0 after reset. The advance flag is high during the step in which the count equals `TIMER_MOD`-1. Seen from reset, the first east-west go therefore lasts exactly five steps.
- R4: The lamp codes in the same bit order are:
  - east-west go: 011110
  - east-west warning: 011101
  - north-south go: 110011
  - north-south warning: 101011
- R5: A go phase holds until a step in which the selected advance signal is 1. It then moves to the warning phase of the same road.
- R6: A warning phase always lasts exactly one step. It then moves unconditionally to the other road's go phase, so a yellow lamp is lit for exactly one step.
- R7: The lamps are registered. After each step they show the code of the phase that was current before that step.
- R8: With the override off, the steady cycle on each road is 4 steps green, 1 step yellow and 5 steps red.
- R9: When `ovr_en` is 1, `ovr_val` replaces the internal advance flag for the go-phase decision. The timer keeps counting regardless.
- R10: Each road always has exactly one lamp lit. At least one of the two roads shows red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ovr_en | input | 1 | Selects the external advance value instead of the timer |
| ovr_val | input | 1 | External advance value used while `ovr_en` is 1 |
| ns_red_n | output | 1 | North-south red lamp, low = lit |
| ns_yel_n | output | 1 | North-south yellow lamp, low = lit |
| ns_grn_n | output | 1 | North-south green lamp, low = lit |
| ew_red_n | output | 1 | East-west red lamp, low = lit |
| ew_yel_n | output | 1 | East-west yellow lamp, low = lit |
| ew_grn_n | output | 1 | East-west green lamp, low = lit |

## Verification
The in-line properties hold on every clock:
- lamps stay still between step enables;
- the divider enable and the timer advance flag never occur on two steps in a row;
- a yellow lamp never survives a second step;
- each road has one lit lamp;
- at least one road is red.

Only the bench scenarios can show the following:
- the full 4/1/5 phase lengths;
- the five-step first green after reset;
- the exact code in each phase;
- the one-step output lag;
- the effect of holding or pulsing the override.

A cycle-level model driven by seeded random override and reset traffic compares the lamps on every clock.

// File: rtl/traffic_seq_pkg.sv
package traffic_seq_pkg;

   typedef enum logic [1:0] {
      PH_EW_GO   = 2'b00,
      PH_EW_WARN = 2'b01,
      PH_NS_GO   = 2'b10,
      PH_NS_WARN = 2'b11
   } phase_e;

   localparam int LAMP_W = 6;

   // bit order: ns red, ns yellow, ns green, ew red, ew yellow, ew green; 0 = lit
   function automatic logic [LAMP_W-1:0] lamp_code(input phase_e ph);
      logic [LAMP_W-1:0] code;
      case (ph)
         PH_EW_GO:   code = 6'b011110;
         PH_EW_WARN: code = 6'b011101;
         PH_NS_GO:   code = 6'b110011;
         PH_NS_WARN: code = 6'b101011;
         default:    code = 6'b011110;
      endcase
      return code;
   endfunction

endpackage

// File: rtl/step_divider.sv
module step_divider #(
   parameter int DIV_RATIO = 4
) (
   input  logic clk,
   input  logic rst,
   output logic step
);
   localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

   logic [CW-1:0] cnt;

   generate
      if (DIV_RATIO < 1) begin : g_bad_ratio
         $error("step_divider: DIV_RATIO must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign step = (cnt == LAST);

   generate
      if (DIV_RATIO > 1) begin : g_step_gap
         // R2: enables are separated by idle clocks
         a_r2_step_gap: assert property (@(posedge clk) disable iff (rst)
            step |=> !step);
      end
   endgenerate

endmodule

// File: rtl/cycle_timer.sv
module cycle_timer #(
   parameter int TIMER_MOD = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic step,
   output logic advance
);
   localparam int TW = (TIMER_MOD > 1) ? $clog2(TIMER_MOD) : 1;
   localparam logic [TW-1:0] LAST = TW'(TIMER_MOD - 1);

   logic [TW-1:0] cnt;

   generate
      if (TIMER_MOD < 2) begin : g_bad_mod
         $error("cycle_timer: TIMER_MOD must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (step) begin
         if (cnt == LAST) cnt <= '0;
         else             cnt <= cnt + 1'b1;
      end
   end

   assign advance = (cnt == LAST);

   // R3: the terminal count lasts a single step
   a_r3_advance_single: assert property (@(posedge clk) disable iff (rst)
      (advance && step) |=> !advance);

endmodule

// File: rtl/light_fsm.sv
module light_fsm
   import traffic_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic              advance,
   output logic [LAMP_W-1:0] lamps
);
   phase_e phase, phase_nx;

   always_comb begin
      phase_nx = phase;
      case (phase)
         PH_EW_GO:   if (advance) phase_nx = PH_EW_WARN;
         PH_EW_WARN: phase_nx = PH_NS_GO;
         PH_NS_GO:   if (advance) phase_nx = PH_NS_WARN;
         PH_NS_WARN: phase_nx = PH_EW_GO;
         default:    phase_nx = PH_EW_GO;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_EW_GO;
         lamps <= lamp_code(PH_EW_GO);
      end else if (step) begin
         phase <= phase_nx;
         lamps <= lamp_code(phase);
      end
   end

   // R2: lamps only move on a step enable
   a_r2_lamps_hold: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(lamps));

   // R6: a yellow lamp is gone after the next step
   a_r6_yellow_one_step: assert property (@(posedge clk) disable iff (rst)
      (step && (!lamps[4] || !lamps[1])) |=> (lamps[4] && lamps[1]));

   // R10: one lamp lit per road
   a_r10_one_lamp_per_road: assert property (@(posedge clk) disable iff (rst)
      ($countones(lamps[5:3]) == 2) && ($countones(lamps[2:0]) == 2));

   // R10: at least one road is held at red
   a_r10_one_road_red: assert property (@(posedge clk) disable iff (rst)
      !lamps[5] || !lamps[2]);

endmodule

// File: rtl/traffic_seq_top.sv
module traffic_seq_top
   import traffic_seq_pkg::*;
#(
   parameter int DIV_RATIO    = 4,
   parameter int TIMER_MOD    = 5,
   parameter bit HAS_OVERRIDE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic ovr_en,
   input  logic ovr_val,
   output logic ns_red_n,
   output logic ns_yel_n,
   output logic ns_grn_n,
   output logic ew_red_n,
   output logic ew_yel_n,
   output logic ew_grn_n
);
   logic              step;
   logic              timer_adv;
   logic              adv_sel;
   logic [LAMP_W-1:0] lamps;

   step_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
      .clk  (clk),
      .rst  (rst),
      .step (step)
   );

   cycle_timer #(.TIMER_MOD(TIMER_MOD)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .step    (step),
      .advance (timer_adv)
   );

   generate
      if (HAS_OVERRIDE) begin : g_ovr
         assign adv_sel = ovr_en ? ovr_val : timer_adv;
      end else begin : g_no_ovr
         logic unused_ovr;
         assign unused_ovr = ovr_en ^ ovr_val;
         assign adv_sel    = timer_adv;
      end
   endgenerate

   light_fsm u_fsm (
      .clk     (clk),
      .rst     (rst),
      .step    (step),
      .advance (adv_sel),
      .lamps   (lamps)
   );

   assign {ns_red_n, ns_yel_n, ns_grn_n, ew_red_n, ew_yel_n, ew_grn_n} = lamps;

endmodule

// File: tb/tb_traffic_seq_top.sv
module tb_traffic_seq_top;
   localparam int B_DIV = 4;
   localparam int B_MOD = 5;
   localparam logic [5:0] C_EWG = 6'b011110;
   localparam logic [5:0] C_EWY = 6'b011101;
   localparam logic [5:0] C_NSG = 6'b110011;
   localparam logic [5:0] C_NSY = 6'b101011;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst = 1'b1, ovr_en = 1'b0, ovr_val = 1'b0;
   logic ns_red_n, ns_yel_n, ns_grn_n, ew_red_n, ew_yel_n, ew_grn_n;

   traffic_seq_top #(.DIV_RATIO(B_DIV), .TIMER_MOD(B_MOD), .HAS_OVERRIDE(1'b1)) dut (
      .clk(clk), .rst(rst), .ovr_en(ovr_en), .ovr_val(ovr_val),
      .ns_red_n(ns_red_n), .ns_yel_n(ns_yel_n), .ns_grn_n(ns_grn_n),
      .ew_red_n(ew_red_n), .ew_yel_n(ew_yel_n), .ew_grn_n(ew_grn_n)
   );

   function automatic logic [5:0] code_of(input logic [1:0] ph);
      case (ph)
         2'd0: return C_EWG;
         2'd1: return C_EWY;
         2'd2: return C_NSG;
         default: return C_NSY;
      endcase
   endfunction

   function automatic logic [1:0] next_of(input logic [1:0] ph, input logic adv);
      case (ph)
         2'd0: return adv ? 2'd1 : 2'd0;
         2'd1: return 2'd2;
         2'd2: return adv ? 2'd3 : 2'd2;
         default: return 2'd0;
      endcase
   endfunction

   // cycle-level reference built from the requirements
   int         m_div, m_cnt;
   logic [1:0] m_ph;
   logic [5:0] m_lamps;
   logic       m_ticked;
   always @(posedge clk) begin
      if (rst) begin
         m_div <= 0; m_cnt <= 0; m_ph <= 2'd0; m_lamps <= C_EWG; m_ticked <= 1'b0;
      end else if (m_div == B_DIV - 1) begin
         m_div    <= 0;
         m_cnt    <= (m_cnt == B_MOD - 1) ? 0 : m_cnt + 1;
         m_lamps  <= code_of(m_ph);
         m_ph     <= next_of(m_ph, ovr_en ? ovr_val : (m_cnt == B_MOD - 1));
         m_ticked <= 1'b1;
      end else begin
         m_div    <= m_div + 1;
         m_ticked <= 1'b0;
      end
   end

   int errors = 0, checks = 0;
   logic [5:0] prev_l;
   bit         have_prev = 0;
   logic [5:0] samples [0:31];
   int         nsamp = 0;
   bit         rec = 0;

   function automatic logic [5:0] lamps_now();
      return {ns_red_n, ns_yel_n, ns_grn_n, ew_red_n, ew_yel_n, ew_grn_n};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      logic [5:0] l;
      @(negedge clk);
      l = lamps_now();
      chk(l == m_lamps, "R7 lamps vs model", l, m_lamps);
      if (!rst && have_prev && !m_ticked)
         chk(l == prev_l, "R2 hold between enables", l, prev_l);
      chk(($countones(l[5:3]) == 2) && ($countones(l[2:0]) == 2) && (!l[5] || !l[2]),
          "R10 one lamp per road, one road red", l, 0);
      prev_l    = l;
      have_prev = 1;
      if (rec && m_ticked && nsamp < 32) begin
         samples[nsamp] = l;
         nsamp++;
      end
   endtask

   function automatic int count_code(input int lo, input int hi, input logic [5:0] mask, input logic [5:0] val);
      int n = 0;
      for (int i = lo; i <= hi; i++) if ((samples[i] & mask) == val) n++;
      return n;
   endfunction

   initial begin : watchdog
      #800000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin : main
      int seed;
      seed = $urandom(32'h1d5e_0a17);
      // R1: reset state
      rst = 1; ovr_en = 0; ovr_val = 0;
      repeat (3) step();
      chk(lamps_now() == C_EWG, "R1 reset code", lamps_now(), C_EWG);
      rst = 0;
      rec = 1; nsamp = 0;
      repeat (B_DIV - 1) step();
      chk(lamps_now() == C_EWG, "R1 before first enable", lamps_now(), C_EWG);
      for (int k = 0; k < 200 && nsamp < 25; k++) step();
      rec = 0;
      chk(nsamp == 25, "R2 enable count", nsamp, 25);
      chk(count_code(0, 4, 6'h3f, C_EWG) == 5 && samples[5] == C_EWY,
          "R3 first green lasts five steps", count_code(0, 4, 6'h3f, C_EWG), 5);
      chk(samples[0] == C_EWG, "R4 ew go code", samples[0], C_EWG);
      chk(samples[5] == C_EWY, "R4 ew warning code", samples[5], C_EWY);
      chk(samples[6] == C_NSG, "R4 ns go code", samples[6], C_NSG);
      chk(samples[10] == C_NSY, "R4 ns warning code", samples[10], C_NSY);
      chk(samples[15] == C_EWY && samples[16] == C_NSG, "R6 yellow then other green", samples[16], C_NSG);
      chk(count_code(11, 20, 6'b000001, 6'b000000) == 4, "R8 ew green 4", count_code(11, 20, 6'b000001, 0), 4);
      chk(count_code(11, 20, 6'b000010, 6'b000000) == 1, "R8 ew yellow 1", count_code(11, 20, 6'b000010, 0), 1);
      chk(count_code(11, 20, 6'b000100, 6'b000000) == 5, "R8 ew red 5", count_code(11, 20, 6'b000100, 0), 5);
      chk(count_code(6, 15, 6'b001000, 6'b000000) == 4, "R8 ns green 4", count_code(6, 15, 6'b001000, 0), 4);
      chk(count_code(6, 15, 6'b010000, 6'b000000) == 1, "R8 ns yellow 1", count_code(6, 15, 6'b010000, 0), 1);
      chk(count_code(6, 15, 6'b100000, 6'b000000) == 5, "R8 ns red 5", count_code(6, 15, 6'b100000, 0), 5);

      // R9 and R5: override holds a go phase, then a pulse releases it
      rst = 1; repeat (2) step(); rst = 0;
      ovr_en = 1; ovr_val = 0;
      repeat (12 * B_DIV) step();
      chk(lamps_now() == C_EWG, "R9 R5 green held by override", lamps_now(), C_EWG);
      ovr_val = 1;
      repeat (B_DIV) step();
      ovr_val = 0;
      repeat (B_DIV) step();
      chk(lamps_now() == C_EWY, "R9 override pulse gives yellow", lamps_now(), C_EWY);
      repeat (6 * B_DIV) step();
      chk(lamps_now() == C_NSG, "R9 R5 ns green held", lamps_now(), C_NSG);
      ovr_en = 0;

      // random traffic on override and reset
      for (int i = 0; i < 4000; i++) begin
         rst     = ($urandom % 700) == 0;
         ovr_en  = ($urandom % 8) == 0;
         ovr_val = $urandom % 2;
         step();
      end
      rst = 0; ovr_en = 0;
      repeat (10) step();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule